// File: doc/BRIEF.md
# Wake-up Input Controller with Dual-Role Status Register

This block watches four external wake-up inputs and exposes them through one 4-bit register on a simple register bus. A write loads four control bits. The low pair configures inputs 0 and 1 together, and the high pair configures inputs 2 and 3 together. Each pair selects one of four sensitivities: off, high level, low level, or either level. A read returns four status bits that sit in the same bit positions as the inputs they describe.

The power mode arrives as an input. In the two low-power modes (Sleep and Stop), the first enabled input that reaches its configured level is captured into a latch, and a one-clock wake request is raised. The latched source stays on the status bits until the first read strobe after the wake. That read returns the latched value. From then on the status bits show the live level of each input. In the two active modes (Normal and Standby) the inputs therefore work as general-purpose inputs.

A watchdog timeout that arrives after a Stop-mode wake, and before that first read, erases the latched source bits. Any of several mode-transition reset conditions clears the control bits and the status latch synchronously. An asynchronous active-low reset clears everything; the reset is expected to be released synchronously. Every input passes through a two-flop synchronizer before it is used.

Top module: `wkin_ctrl`

## Requirements
- R1: After `rst_n` is asserted, `rd_data_o` reads 0000 and `wake_req_o` is 0. All control bits, latch bits and synchronizer stages are 0.
- R2: When `wr_en_i` is high at a clock edge, the control bits take `wr_data_i`. Bits [1:0] configure inputs 0 and 1, and bits [3:2] configure inputs 2 and 3.
- R3: The 2-bit sensitivity code is 00 = off, 01 = wake on high level, 10 = wake on low level, 11 = wake on either level.
- R4: Each input reaches the status path through two flops. A change on `pins_i` shows on `rd_data_o` after exactly two rising edges.
- R5: In mode 00 (Normal) and mode 01 (Standby), nothing is latched, `wake_req_o` stays 0, and status bit i gives the live synchronized level of input i.
- R6: In mode 10 (Sleep) and mode 11 (Stop), when no source is held and at least one enabled input matches its sensitivity, two things happen at the next edge. The latch takes the set of all matching inputs, and `wake_req_o` is high for exactly one clock.
- R7: While a source is held, `rd_data_o` returns the latch, and further matches neither re-latch nor pulse again. A read strobe returns the latch and ends the hold, so later reads return live levels.
- R8: An input whose pair is set to 00 never appears in the latch and never causes a wake request.
- R9: When a source is held from a Stop-mode wake, a `wdog_to_i` pulse clears the latched bits to 0000. The hold stays in place until the next read, and that read returns 0000.
- R10: When a source is held from a Sleep-mode wake, `wdog_to_i` has no effect on the latched bits.
- R11: When any bit of `xrst_i` is high at an edge, the control bits, the latch and the hold are cleared. This takes priority over a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Power mode: 00 Normal, 01 Standby, 10 Sleep, 11 Stop |
| xrst_i | input | 4 | Mode-transition reset conditions; any high bit clears the register |
| pins_i | input | 4 | Wake-up inputs, bit i = input i |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 4 | Control bits for the write |
| rd_en_i | input | 1 | Register read strobe |
| rd_data_o | output | 4 | Status bits: latched wake source or live levels |
| wdog_to_i | input | 1 | Watchdog timeout pulse |
| wake_req_o | output | 1 | One-clock wake request |

## Verification
The bench targets the handover at the first read. A design that cleared the hold before returning the latch would show live levels on that read, and one that never cleared it would keep reporting a stale source. It also separates the watchdog behaviour after Stop wakes from that after Sleep wakes; a design that ignored the stored mode would either erase a Sleep-mode source or keep a Stop-mode one. Disabled pairs are driven to levels that would otherwise match, so a design that leaked a disabled input into the latch or the wake request is caught. A mode-transition reset is raised in the same cycle as a write, so a design with the wrong priority would keep the written configuration and wake again.

// File: rtl/wkin_pkg.sv
package wkin_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL  = 2'b00,
    MODE_STANDBY = 2'b01,
    MODE_SLEEP   = 2'b10,
    MODE_STOP    = 2'b11
  } pwr_mode_e;

  typedef enum logic [1:0] {
    SENSE_OFF  = 2'b00,
    SENSE_HIGH = 2'b01,
    SENSE_LOW  = 2'b10,
    SENSE_ANY  = 2'b11
  } sense_e;

  function automatic logic is_low_power(input pwr_mode_e m);
    return (m == MODE_SLEEP) || (m == MODE_STOP);
  endfunction

endpackage

// File: rtl/wkin_sync.sv
module wkin_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/wkin_match.sv
module wkin_match
  import wkin_pkg::*;
#(
  parameter int NUM_IN = 4,
  parameter int GROUP  = 2,
  localparam int CTRL_W = 2 * (NUM_IN / GROUP)
) (
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic [NUM_IN-1:0] level_i,
  output logic [NUM_IN-1:0] hit_o,
  output logic [NUM_IN-1:0] en_o
);

  for (genvar i = 0; i < NUM_IN; i++) begin : g_in
    localparam int GI = i / GROUP;
    sense_e cfg;
    assign cfg = sense_e'(ctrl_i[2*GI +: 2]);

    always_comb begin
      unique case (cfg)
        SENSE_OFF:  hit_o[i] = 1'b0;
        SENSE_HIGH: hit_o[i] = level_i[i];
        SENSE_LOW:  hit_o[i] = ~level_i[i];
        default:    hit_o[i] = 1'b1;
      endcase
    end

    assign en_o[i] = (cfg != SENSE_OFF);
  end

endmodule

// File: rtl/wkin_latch.sv
module wkin_latch #(
  parameter int NUM_IN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              low_power_i,
  input  logic              stop_i,
  input  logic [NUM_IN-1:0] hits_i,
  input  logic              rd_i,
  input  logic              wdog_i,
  output logic              hold_o,
  output logic [NUM_IN-1:0] latch_o,
  output logic              wake_o
);

  logic              hold_q, hold_d;
  logic              stop_q, stop_d;
  logic              wake_q, wake_d;
  logic [NUM_IN-1:0] latch_q, latch_d;

  always_comb begin
    hold_d  = hold_q;
    stop_d  = stop_q;
    latch_d = latch_q;
    wake_d  = 1'b0;
    if (clr_i) begin
      hold_d  = 1'b0;
      stop_d  = 1'b0;
      latch_d = '0;
    end else if (!hold_q) begin
      if (low_power_i && (|hits_i)) begin
        hold_d  = 1'b1;
        stop_d  = stop_i;
        latch_d = hits_i;
        wake_d  = 1'b1;
      end
    end else if (rd_i) begin
      hold_d  = 1'b0;
      latch_d = '0;
    end else if (wdog_i && stop_q) begin
      latch_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= 1'b0;
      stop_q  <= 1'b0;
      latch_q <= '0;
      wake_q  <= 1'b0;
    end else begin
      hold_q  <= hold_d;
      stop_q  <= stop_d;
      latch_q <= latch_d;
      wake_q  <= wake_d;
    end
  end

  assign hold_o  = hold_q;
  assign latch_o = latch_q;
  assign wake_o  = wake_q;

  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wake_q |=> !wake_q);

  assert_read_ends_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && rd_i && !clr_i) |=> !hold_q);

  assert_stop_wdog_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && stop_q && wdog_i && !clr_i) |=> (latch_q == '0));

  assert_sleep_wdog_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && !stop_q && wdog_i && !rd_i && !clr_i) |=> $stable(latch_q));

  assert_modeclr_latch_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (!hold_q && (latch_q == '0) && !wake_q));

endmodule

// File: rtl/wkin_ctrl.sv
module wkin_ctrl
  import wkin_pkg::*;
#(
  parameter int NUM_IN      = 4,
  parameter int GROUP       = 2,
  parameter int SYNC_STAGES = 2,
  parameter int NUM_XRST    = 4,
  localparam int CTRL_W = 2 * (NUM_IN / GROUP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic [NUM_XRST-1:0] xrst_i,
  input  logic [NUM_IN-1:0] pins_i,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  output logic [NUM_IN-1:0] rd_data_o,
  input  logic              wdog_to_i,
  output logic              wake_req_o
);

  pwr_mode_e         mode;
  logic              clr;
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [NUM_IN-1:0] live;
  logic [NUM_IN-1:0] hits;
  logic [NUM_IN-1:0] en_mask;
  logic              hold;
  logic [NUM_IN-1:0] latch;

  assign mode = pwr_mode_e'(mode_i);
  assign clr  = |xrst_i;

  always_comb begin
    ctrl_d = ctrl_q;
    if (clr)          ctrl_d = '0;
    else if (wr_en_i) ctrl_d = wr_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  wkin_sync #(.W(NUM_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pins_i),
    .q_o   (live)
  );

  wkin_match #(.NUM_IN(NUM_IN), .GROUP(GROUP)) u_match (
    .ctrl_i  (ctrl_q),
    .level_i (live),
    .hit_o   (hits),
    .en_o    (en_mask)
  );

  wkin_latch #(.NUM_IN(NUM_IN)) u_latch (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (clr),
    .low_power_i (is_low_power(mode)),
    .stop_i      (mode == MODE_STOP),
    .hits_i      (hits),
    .rd_i        (rd_en_i),
    .wdog_i      (wdog_to_i),
    .hold_o      (hold),
    .latch_o     (latch),
    .wake_o      (wake_req_o)
  );

  assign rd_data_o = hold ? latch : live;

  assert_write_ctrl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !clr) |=> (ctrl_q == $past(wr_data_i)));

  assert_modeclr_ctrl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (ctrl_q == '0));

  assert_wake_low_power_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req_o |-> $past(mode_i[1]));

  assert_no_disabled_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req_o |-> ((latch & ~$past(en_mask)) == '0));

endmodule

// File: tb/wkin_ctrl_tb_top.sv
module wkin_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [3:0] xrst = 4'h0;
  logic [3:0] pins = 4'h0;
  logic       wr_en = 1'b0;
  logic [3:0] wdata = 4'h0;
  logic       rd_en = 1'b0;
  logic [3:0] rd_data;
  logic       wdog = 1'b0;
  logic       wake_req;

  int checks = 0;
  int failures = 0;
  int wake_cnt = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wkin_ctrl dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (mode),
    .xrst_i     (xrst),
    .pins_i     (pins),
    .wr_en_i    (wr_en),
    .wr_data_i  (wdata),
    .rd_en_i    (rd_en),
    .rd_data_o  (rd_data),
    .wdog_to_i  (wdog),
    .wake_req_o (wake_req)
  );

  // Behavioural reference: queue models input delay, plain variables model the register
  logic [3:0] pq[$];
  logic [3:0] m_ctrl, m_lat;
  bit         m_hold, m_stop, m_wake;

  function automatic logic [3:0] q_level();
    if (pq.size() >= 2) return pq[0];
    return 4'h0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pq.delete();
      m_ctrl = 0; m_lat = 0; m_hold = 0; m_stop = 0; m_wake = 0;
    end else begin
      logic [3:0] lvl, hits;
      lvl = q_level();
      hits = 0;
      for (int i = 0; i < 4; i++) begin
        int cfg;
        cfg = (m_ctrl >> (2 * (i / 2))) & 3;
        if (cfg == 1 && lvl[i]) hits[i] = 1;
        if (cfg == 2 && !lvl[i]) hits[i] = 1;
        if (cfg == 3) hits[i] = 1;
      end
      pq.push_back(pins);
      if (pq.size() > 2) void'(pq.pop_front());
      m_wake = 0;
      if (xrst != 0) begin
        m_ctrl = 0; m_lat = 0; m_hold = 0; m_stop = 0;
      end else begin
        if (!m_hold && mode >= 2 && hits != 0) begin
          m_lat = hits; m_hold = 1; m_stop = (mode == 3); m_wake = 1;
        end else if (m_hold && rd_en) begin
          m_hold = 0; m_lat = 0;
        end else if (m_hold && wdog && m_stop) begin
          m_lat = 0;
        end
        if (wr_en) m_ctrl = wdata;
      end
    end
  end

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      #1;
      chk("R5/R6/R7 model rd_data", rd_data, m_hold ? m_lat : q_level());
      chk("R6 model wake_req", {3'b0, wake_req}, {3'b0, m_wake});
    end
  end

  always @(negedge clk) if (rst_n && wake_req) wake_cnt++;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ctrl(input logic [3:0] v);
    @(negedge clk); wr_en = 1; wdata = v;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd_reg(output logic [3:0] v);
    @(negedge clk); rd_en = 1; #1 v = rd_data;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic wd_pulse();
    @(negedge clk); wdog = 1;
    @(negedge clk); wdog = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [3:0] v;
    tick(3);
    #1 chk("R1 reset rd_data", rd_data, 4'b0000);
    chk("R1 reset wake_req", {3'b0, wake_req}, 4'b0000);
    @(negedge clk) rst_n = 1;

    // R4: two-edge input latency
    @(negedge clk) pins = 4'b1010;
    @(negedge clk); #1 chk("R4 one edge stale", rd_data, 4'b0000);
    @(negedge clk); #1 chk("R4 two edges live", rd_data, 4'b1010);

    // R5: active modes report live levels and never wake
    wr_ctrl(4'b1111);
    tick(4);
    rd_reg(v); chk("R5 normal live", v, 4'b1010);
    @(negedge clk) begin mode = 2'b01; pins = 4'b0101; end
    tick(4);
    rd_reg(v); chk("R5 standby live", v, 4'b0101);
    chk("R5 no wake active", wake_cnt[3:0], 4'd0);

    // Sleep wake, high sensitivity on L0/L1, L2/L3 off (R3, R6, R8, R10, R7)
    wr_ctrl(4'b0001);
    @(negedge clk) pins = 4'b0000;
    tick(4);
    @(negedge clk) mode = 2'b10;
    tick(4);
    chk("R6 no match no wake", wake_cnt[3:0], 4'd0);
    @(negedge clk) pins = 4'b0100;
    tick(5);
    chk("R8 disabled L2 no wake", wake_cnt[3:0], 4'd0);
    @(negedge clk) pins = 4'b0110;
    tick(5);
    chk("R6 sleep wake one pulse", wake_cnt[3:0], 4'd1);
    @(negedge clk) mode = 2'b00;
    wd_pulse();
    tick(2);
    rd_reg(v); chk("R10 sleep wdog keeps source, R8 L2 excluded", v, 4'b0010);
    rd_reg(v); chk("R7 second read live", v, 4'b0110);

    // Stop wake, low sensitivity on L2/L3 (R3, R9)
    @(negedge clk) pins = 4'b1111;
    wr_ctrl(4'b1000);
    tick(4);
    @(negedge clk) mode = 2'b11;
    tick(4);
    chk("R3 low-sense ignores high", wake_cnt[3:0], 4'd1);
    @(negedge clk) pins = 4'b0111;
    tick(5);
    chk("R6 stop wake one pulse", wake_cnt[3:0], 4'd2);
    #1 chk("R7 latch shown before read", rd_data, 4'b1000);
    @(negedge clk) mode = 2'b00;
    wd_pulse();
    tick(2);
    #1 chk("R9 stop wdog clears, hold kept", rd_data, 4'b0000);
    rd_reg(v); chk("R9 first read after wdog", v, 4'b0000);
    rd_reg(v); chk("R7 live after read", v, 4'b0111);

    // Low sensitivity on L0/L1, no re-pulse while held (R3, R7)
    @(negedge clk) pins = 4'b0001;
    wr_ctrl(4'b0010);
    tick(4);
    @(negedge clk) mode = 2'b10;
    tick(5);
    chk("R3 low-sense L1 wake", wake_cnt[3:0], 4'd3);
    tick(6);
    chk("R7 no second pulse while held", wake_cnt[3:0], 4'd3);
    @(negedge clk) mode = 2'b00;
    rd_reg(v); chk("R3 low-sense source", v, 4'b0010);

    // Either-level on L2/L3 (R3)
    @(negedge clk) pins = 4'b0000;
    wr_ctrl(4'b1100);
    tick(3);
    @(negedge clk) mode = 2'b11;
    tick(5);
    chk("R3 any-level wake", wake_cnt[3:0], 4'd4);
    @(negedge clk) mode = 2'b00;
    rd_reg(v); chk("R3 any-level source", v, 4'b1100);
    rd_reg(v); chk("R7 live after any-level", v, 4'b0000);

    // Mode-transition reset beats write (R11, R2)
    wr_ctrl(4'b0101);
    tick(3);
    @(negedge clk) mode = 2'b10;
    @(negedge clk) pins = 4'b0001;
    tick(5);
    chk("R2 written config wakes", wake_cnt[3:0], 4'd5);
    @(negedge clk) begin xrst = 4'b0100; wr_en = 1; wdata = 4'b0101; end
    @(negedge clk) begin xrst = 4'b0000; wr_en = 0; end
    #1 chk("R11 latch cleared, live shown", rd_data, 4'b0001);
    tick(6);
    chk("R11 config cleared over write", wake_cnt[3:0], 4'd5);

    // Reset mid-run (R1)
    @(negedge clk) rst_n = 0;
    #1 chk("R1 async reset clears status", rd_data, 4'b0000);
    chk("R1 async reset wake", {3'b0, wake_req}, 4'b0000);
    @(negedge clk) rst_n = 1;
    tick(2);

    finish_run();
  end

endmodule